// File: doc/BRIEF.md
# Transmit Power Ramp Controller

This block turns a host-loaded ramp shape into a stepped series of DAC codes for one power-amplifier stage. Before a ramp starts, the host fills a 32-entry shape table and loads a target power word. An external sequencer supplies the ramp direction and a trigger. Each output sample is the selected table entry scaled by the target. The sample is held for a programmed number of clock cycles, and the ramp ends after a programmed number of samples.

An output selector chooses what reaches the DAC. In ramp mode the DAC receives the ramp samples. In bypass mode it receives the static target. In pass-through mode it receives I/Q samples streamed from outside. A channel enable lets the DAC of this stage take part or forces its code to zero. One copy of the block drives one DAC, so a transmitter with several amplifier stages uses several copies under a common sequencer.

Top module: `pa_ramp_ctrl`

## Requirements
- R1: After a cycle with `rst_n` low, `dac_code`, `ramp_busy` and `ramp_done` are all 0, and the shape table and the target are cleared to 0.
- R2: Each ramp sample equals (table entry × target) >> 10, using the 10-bit table entry and the 10-bit target that hold when the sample is taken.
- R3: With `seq_dir_up` = 1 at the trigger, the samples use table indices 0, 1, …, N−1 in that order, where N is the effective duration.
- R4: With `seq_dir_up` = 0 at the trigger, the samples use indices N−1 down to 0.
- R5: The first sample appears on `dac_code` in the cycle after the trigger edge. Each sample is held for S cycles, where S is `step_cfg`, and a `step_cfg` of 0 acts as 1.
- R6: The effective duration N is `dur_cfg`, except that 0 acts as 1 and any value above 32 acts as 32.
- R7: After the final sample, `dac_code` keeps the last sample until a new ramp starts.
- R8: `ramp_done` is high for exactly the first cycle in which the final sample is shown. `ramp_busy` is high from the cycle after an accepted trigger until that same cycle, when it falls.
- R9: A `seq_trig` that is sampled while `ramp_busy` is high has no effect on the ramp, its direction, its timing or its samples.
- R10: With `out_mode` = 1 (bypass), `dac_code` equals the stored target.
- R11: With `out_mode` = 2 (pass-through), `dac_code` equals `iq_data` in the same cycle. `out_mode` = 0 selects the ramp samples, and `out_mode` = 3 gives 0.
- R12: With `dac_en` = 0, `dac_code` is 0 whatever the mode. The ramp sequencing continues unchanged, so the current sample appears when `dac_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lut_wr_en | input | 1 | Write strobe for the shape table |
| lut_wr_addr | input | 5 | Table index written |
| lut_wr_data | input | 10 | Table entry value |
| tgt_ld | input | 1 | Load strobe for the target power |
| tgt_data | input | 10 | Target power value |
| step_cfg | input | 8 | Cycles each sample is held (0 acts as 1) |
| dur_cfg | input | 6 | Number of samples in a ramp |
| seq_trig | input | 1 | Ramp start from the sequencer |
| seq_dir_up | input | 1 | 1 = rising ramp, 0 = falling ramp |
| out_mode | input | 2 | 0 ramp, 1 bypass, 2 I/Q pass-through, 3 zero |
| dac_en | input | 1 | Channel enable for this DAC |
| iq_data | input | 10 | Streamed I/Q sample |
| dac_code | output | 10 | Code driven to the DAC |
| ramp_busy | output | 1 | A ramp is in progress |
| ramp_done | output | 1 | One-cycle pulse with the final sample |

## Verification
The end of a ramp and a new trigger can fall in the same cycle. At the edge where the final sample loads, `ramp_busy` is still high, so a trigger there must be dropped. A trigger one cycle later must start a fresh ramp. The bench provokes this by holding `seq_trig` high through a whole ramp. A cycle-accurate reference model then predicts `ramp_busy`, `ramp_done` and `dac_code` on every cycle, including the single cycle in which the old ramp's last sample is shown before the new ramp's first sample.

// File: rtl/pa_ramp_pkg.sv
// Shared constants for the transmit power ramp controller.
// Assumes a single clock domain; output selector codes are fixed here.
package pa_ramp_pkg;
    typedef enum logic [1:0] {
        SEL_RAMP   = 2'd0,
        SEL_BYPASS = 2'd1,
        SEL_IQ     = 2'd2,
        SEL_ZERO   = 2'd3
    } out_sel_e;
endpackage

// File: rtl/ramp_lut.sv
// Ramp shape table: DEPTH entries of W bits, one host write port and one
// combinational read port. Assumes the host does not write while a ramp runs.
module ramp_lut #(
    parameter int DEPTH = 32,
    parameter int W     = 10,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Store one entry; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && wr_addr == AW'(g))
                mem[g] <= wr_data;
        end
    end

    // Read the entry chosen by the sequencer.
    always_comb rd_data = mem[rd_addr];
endmodule

// File: rtl/ramp_sequencer.sv
// Step timer and direction logic. It accepts a trigger only when idle, walks
// the table index up or down, and holds each sample for the step interval.
// Assumes the trigger and configuration are synchronous to clk.
module ramp_sequencer #(
    parameter int DEPTH  = 32,
    parameter int AW     = $clog2(DEPTH),
    parameter int DUR_W  = AW + 1,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              dir_up,
    input  logic [DUR_W-1:0]  dur_cfg,
    input  logic [STEP_W-1:0] step_cfg,
    output logic              load,
    output logic [AW-1:0]     rd_idx,
    output logic              busy,
    output logic              done
);
    logic              busy_q, done_q, dir_q;
    logic [AW-1:0]     idx_q;
    logic [STEP_W-1:0] cnt_q, step_q, step_eff;
    logic [DUR_W-1:0]  left_q, dur_eff;
    logic [AW-1:0]     first_idx;
    logic              accept, tick;

    // Clamp the programmed duration and step to their usable ranges.
    always_comb begin
        if (dur_cfg == '0)
            dur_eff = DUR_W'(1);
        else if (dur_cfg > DUR_W'(DEPTH))
            dur_eff = DUR_W'(DEPTH);
        else
            dur_eff = dur_cfg;
        step_eff = (step_cfg == '0) ? STEP_W'(1) : step_cfg;
    end

    // Decide when a sample is taken and which index it reads.
    always_comb begin
        accept    = trig && !busy_q;
        tick      = busy_q && (cnt_q == '0);
        load      = accept || tick;
        first_idx = dir_up ? '0 : AW'(dur_eff - DUR_W'(1));
        if (accept)
            rd_idx = first_idx;
        else if (dir_q)
            rd_idx = idx_q + AW'(1);
        else
            rd_idx = idx_q - AW'(1);
    end

    // Ramp state: start, per-sample countdown, sample count and end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            dir_q  <= 1'b0;
            idx_q  <= '0;
            cnt_q  <= '0;
            step_q <= '0;
            left_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                idx_q  <= first_idx;
                dir_q  <= dir_up;
                step_q <= step_eff;
                cnt_q  <= step_eff - STEP_W'(1);
                left_q <= dur_eff - DUR_W'(1);
                busy_q <= (dur_eff != DUR_W'(1));
                done_q <= (dur_eff == DUR_W'(1));
            end else if (busy_q) begin
                if (cnt_q != '0) begin
                    cnt_q <= cnt_q - STEP_W'(1);
                end else begin
                    idx_q  <= rd_idx;
                    cnt_q  <= step_q - STEP_W'(1);
                    left_q <= left_q - DUR_W'(1);
                    if (left_q == DUR_W'(1)) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;

    p_busy_ends_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q);
    p_wait_keeps_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |=> $stable(idx_q));
    p_retrigger_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && trig) |=> (dir_q == $past(dir_q) && step_q == $past(step_q)));
    p_samples_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        left_q < DUR_W'(DEPTH));
endmodule

// File: rtl/ramp_out_mux.sv
// Scales the table entry by the target into the sample register, then picks
// what drives the DAC: ramp sample, static target, streamed I/Q or zero.
// Assumes load pulses only when the sequencer takes a new sample.
module ramp_out_mux
    import pa_ramp_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] lut_val,
    input  logic [W-1:0] target,
    input  logic [W-1:0] iq_in,
    input  logic [1:0]   mode,
    input  logic         dac_en,
    output logic [W-1:0] dac_code
);
    logic [2*W-1:0] prod;
    logic [W-1:0]   samp_q;

    // Scale the shape entry by the target power.
    always_comb prod = lut_val * target;

    // Capture the scaled sample and hold it between loads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            samp_q <= '0;
        else if (load)
            samp_q <= prod[2*W-1:W];
    end

    // Select the DAC source.
    always_comb begin
        dac_code = '0;
        if (dac_en) begin
            unique case (out_sel_e'(mode))
                SEL_RAMP:   dac_code = samp_q;
                SEL_BYPASS: dac_code = target;
                SEL_IQ:     dac_code = iq_in;
                SEL_ZERO:   dac_code = '0;
            endcase
        end
    end

    p_hold_between_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(samp_q));
endmodule

// File: rtl/pa_ramp_ctrl.sv
// Transmit power ramp controller for one PA stage. It holds the target power
// register and joins the shape table, the step sequencer and the output mux.
// Assumes the host sets the table and the target before triggering a ramp.
module pa_ramp_ctrl #(
    parameter int DEPTH  = 32,
    parameter int W      = 10,
    parameter int STEP_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int DUR_W = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lut_wr_en,
    input  logic [AW-1:0]     lut_wr_addr,
    input  logic [W-1:0]      lut_wr_data,
    input  logic              tgt_ld,
    input  logic [W-1:0]      tgt_data,
    input  logic [STEP_W-1:0] step_cfg,
    input  logic [DUR_W-1:0]  dur_cfg,
    input  logic              seq_trig,
    input  logic              seq_dir_up,
    input  logic [1:0]        out_mode,
    input  logic              dac_en,
    input  logic [W-1:0]      iq_data,
    output logic [W-1:0]      dac_code,
    output logic              ramp_busy,
    output logic              ramp_done
);
    logic [W-1:0]  tgt_q, lut_val;
    logic [AW-1:0] rd_idx;
    logic          load;

    // Target power register written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tgt_q <= '0;
        else if (tgt_ld)
            tgt_q <= tgt_data;
    end

    ramp_lut #(.DEPTH(DEPTH), .W(W), .AW(AW)) u_lut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(lut_wr_en), .wr_addr(lut_wr_addr), .wr_data(lut_wr_data),
        .rd_addr(rd_idx), .rd_data(lut_val)
    );

    ramp_sequencer #(.DEPTH(DEPTH), .AW(AW), .DUR_W(DUR_W), .STEP_W(STEP_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .trig(seq_trig), .dir_up(seq_dir_up),
        .dur_cfg(dur_cfg), .step_cfg(step_cfg),
        .load(load), .rd_idx(rd_idx),
        .busy(ramp_busy), .done(ramp_done)
    );

    ramp_out_mux #(.W(W)) u_mux (
        .clk(clk), .rst_n(rst_n),
        .load(load), .lut_val(lut_val), .target(tgt_q), .iq_in(iq_data),
        .mode(out_mode), .dac_en(dac_en), .dac_code(dac_code)
    );
endmodule

// File: tb/sim_pa_ramp_ctrl.sv
`timescale 1ns/1ps
// Bench for pa_ramp_ctrl: a behavioural model predicts every output on every
// cycle. Inputs change on the falling edge; outputs are compared 8 ns after
// each rising edge.
module sim_pa_ramp_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lut_wr_en = 1'b0;
    logic [4:0] lut_wr_addr = '0;
    logic [9:0] lut_wr_data = '0;
    logic       tgt_ld = 1'b0;
    logic [9:0] tgt_data = '0;
    logic [7:0] step_cfg = 8'd1;
    logic [5:0] dur_cfg = 6'd1;
    logic       seq_trig = 1'b0;
    logic       seq_dir_up = 1'b1;
    logic [1:0] out_mode = 2'd0;
    logic       dac_en = 1'b1;
    logic [9:0] iq_data = '0;
    logic [9:0] dac_code;
    logic       ramp_busy, ramp_done;

    int checks = 0;
    int fails  = 0;
    string phase = "R1";

    pa_ramp_ctrl u0 (.*);

    always #10 clk = ~clk;

    // Reference model state.
    int m_lut [32];
    int m_tgt, m_samp, m_wait, m_step;
    bit m_busy, m_done;
    int q[$];

    // Advance the model at each rising edge from the bench-driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_lut[i]) m_lut[i] = 0;
            m_tgt = 0; m_samp = 0; m_wait = 0; m_step = 1;
            m_busy = 0; m_done = 0; q.delete();
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (m_wait > 1) m_wait--;
                else begin
                    m_samp = q.pop_front();
                    m_wait = m_step;
                    if (q.size() == 0) begin m_busy = 0; m_done = 1; end
                end
            end else if (seq_trig) begin
                int n;
                n = (dur_cfg == 0) ? 1 : (dur_cfg > 32 ? 32 : int'(dur_cfg));
                m_step = (step_cfg == 0) ? 1 : int'(step_cfg);
                for (int k = 0; k < n; k++) begin
                    int ix;
                    ix = seq_dir_up ? k : n - 1 - k;
                    q.push_back((m_lut[ix] * m_tgt) >> 10);
                end
                m_samp = q.pop_front();
                m_wait = m_step;
                if (q.size() == 0) m_done = 1; else m_busy = 1;
            end
            if (lut_wr_en) m_lut[lut_wr_addr] = int'(lut_wr_data);
            if (tgt_ld) m_tgt = int'(tgt_data);
        end
    end

    function automatic int exp_dac();
        if (!dac_en) return 0;
        case (out_mode)
            2'd0: return m_samp;
            2'd1: return m_tgt;
            2'd2: return int'(iq_data);
            default: return 0;
        endcase
    endfunction

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", phase, what, act, exp, $time);
        end
    endtask

    // Compare every output once per cycle, away from the edges.
    always @(posedge clk) begin
        #8;
        check("dac_code", int'(dac_code), exp_dac());
        check("ramp_busy", int'(ramp_busy), int'(m_busy));
        check("ramp_done", int'(ramp_done), int'(m_done));
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Start one ramp and wait for it to finish with some idle margin.
    task automatic ramp(bit up, int dur, int step, int extra);
        int n, s;
        n = (dur == 0) ? 1 : (dur > 32 ? 32 : dur);
        s = (step == 0) ? 1 : step;
        @(negedge clk);
        seq_dir_up = up; dur_cfg = 6'(dur); step_cfg = 8'(step); seq_trig = 1'b1;
        @(negedge clk);
        seq_trig = 1'b0;
        cyc(n * s + extra);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset clears outputs.
        cyc(4);
        rst_n = 1'b1;
        phase = "R2";
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            lut_wr_en = 1'b1; lut_wr_addr = 5'(i);
            lut_wr_data = (i == 31) ? 10'd1023 : 10'(i * 33);
        end
        @(negedge clk);
        lut_wr_en = 1'b0; tgt_ld = 1'b1; tgt_data = 10'd1023;
        @(negedge clk);
        tgt_ld = 1'b0;
        phase = "R3"; ramp(1'b1, 8, 3, 2);
        phase = "R7"; cyc(6);
        phase = "R4"; ramp(1'b0, 5, 1, 3);
        phase = "R5"; ramp(1'b1, 4, 0, 3);
        phase = "R5"; ramp(1'b0, 3, 5, 3);
        // R9: trigger again mid-ramp with the other direction.
        phase = "R9";
        @(negedge clk);
        seq_dir_up = 1'b1; dur_cfg = 6'd6; step_cfg = 8'd4; seq_trig = 1'b1;
        @(negedge clk); seq_trig = 1'b0;
        cyc(5);
        seq_dir_up = 1'b0; dur_cfg = 6'd2; step_cfg = 8'd1; seq_trig = 1'b1;
        @(negedge clk); seq_trig = 1'b0;
        cyc(25);
        // R8: trigger held through the end of a ramp restarts it one cycle later.
        phase = "R8";
        @(negedge clk);
        seq_dir_up = 1'b1; dur_cfg = 6'd3; step_cfg = 8'd2; seq_trig = 1'b1;
        cyc(8);
        seq_trig = 1'b0;
        cyc(8);
        phase = "R6"; ramp(1'b1, 0, 2, 3);
        phase = "R6"; ramp(1'b0, 40, 1, 3);
        phase = "R6"; ramp(1'b1, 32, 1, 3);
        // R2: a half-scale target.
        phase = "R2";
        @(negedge clk); tgt_ld = 1'b1; tgt_data = 10'd512;
        @(negedge clk); tgt_ld = 1'b0;
        ramp(1'b1, 10, 2, 3);
        // R10: bypass shows the stored target.
        phase = "R10";
        @(negedge clk); out_mode = 2'd1;
        cyc(3);
        tgt_ld = 1'b1; tgt_data = 10'd777;
        @(negedge clk); tgt_ld = 1'b0;
        cyc(3);
        // R11: pass-through follows iq_data in the same cycle, and code 3 gives zero.
        phase = "R11";
        out_mode = 2'd2;
        for (int i = 0; i < 8; i++) begin
            iq_data = 10'((i * 137 + 11) % 1024);
            @(negedge clk);
        end
        out_mode = 2'd3;
        cyc(3);
        // R12: a disabled channel drives zero while the ramp keeps running.
        phase = "R12";
        out_mode = 2'd0; dac_en = 1'b0;
        @(negedge clk);
        seq_dir_up = 1'b1; dur_cfg = 6'd6; step_cfg = 8'd3; seq_trig = 1'b1;
        @(negedge clk); seq_trig = 1'b0;
        cyc(7);
        dac_en = 1'b1;
        cyc(15);
        phase = "R1";
        rst_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule